// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B. It has two directions, and each direction has its own storage register. The A-to-B register captures the A bus. The B-to-A register captures the B bus. Each direction also has a select input and an output enable. The select chooses whether that direction drives live data from the opposite bus or the value it stored earlier. The two output enables have opposite polarity. The enable for A-to-B is active high, and the enable for B-to-A is active low.

All logic runs on one system clock. The two capture inputs are single-cycle strobes that load a register at the next rising edge. A load happens whatever the select and enable inputs are doing. Each bus is modelled as three separate vectors: a resolved input, a data output and a per-bit output enable. Outside the block, a resolution model with a keeper joins the output of one side back into the input of the other side.

With that loop-back in place, the block supports these uses:
- isolation;
- storing from either bus;
- loading both registers from one bus;
- live or stored transfer in each direction;
- driving both stored values at the same time;
- a hold loop that keeps both buses at their last value once every outside driver has released.

A sticky flag records any cycle in which both strobes fire while either select is 1. Such a load needs the two strobes to be staggered.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to 0 and clears the error flag. After reset, with both selects at 1, both data outputs read 0.
- R2: A 1 on `cap_ab` in a cycle loads `a_in` into the A-to-B register at that clock edge, for any value of the selects and enables. With `cap_ab` at 0 the register holds its value.
- R3: A 1 on `cap_ba` in a cycle loads `b_in` into the B-to-A register at that clock edge, for any value of the selects and enables. With `cap_ba` at 0 the register holds its value.
- R4: `b_out` equals `a_in` combinationally when `sel_ab` is 0. `b_out` equals the A-to-B register when `sel_ab` is 1.
- R5: `a_out` equals `b_in` combinationally when `sel_ba` is 0. `a_out` equals the B-to-A register when `sel_ba` is 1.
- R6: Every bit of `b_oe` equals `en_ab` (active high). Every bit of `a_oe` equals the inverse of `en_ba_n` (active low).
- R7: With `en_ab`=0 and `en_ba_n`=1 neither bus is driven. Both buses then follow only their outside drivers or their keepers.
- R8: With `en_ab`=1, `en_ba_n`=0 and both selects at 1, the stored A value appears on the B bus and the stored B value appears on the A bus at the same time.
- R9: With both directions enabled and both selects at 0, the two buses reinforce each other. They keep their last value after the outside drivers release.
- R10: A value driven on A and passed live onto B loads into both registers when both strobes fire in the same cycle with both selects at 0. The error flag stays 0.
- R11: `stagger_err` goes to 1 in the cycle after a cycle in which both strobes are 1 and either select is 1. It stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Resolved value of the A bus |
| a_out | output | W | Data this block puts on the A bus |
| a_oe | output | W | Per-bit drive enable for the A bus |
| b_in | input | W | Resolved value of the B bus |
| b_out | output | W | Data this block puts on the B bus |
| b_oe | output | W | Per-bit drive enable for the B bus |
| cap_ab | input | 1 | Load strobe for the A-to-B register |
| cap_ba | input | 1 | Load strobe for the B-to-A register |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | Drive enable toward B, active high |
| en_ba_n | input | 1 | Drive enable toward A, active low |
| stagger_err | output | 1 | Sticky flag for simultaneous strobes with a stored select |

## Verification
The hardest states to reach are the ones that exist only because the block's outputs loop back to its own inputs through the bus: the hold loop and the load of both registers from one bus. Neither can be set up by driving ports directly. The bench therefore holds a keeper and a resolution model for each bus. It re-evaluates them several times in small time steps until the loop settles. Directed sequences then release every outside driver while both live paths are on, and fire both strobes through the live path. Random cycles only drive a bus from outside when this block leaves that bus undriven.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    // Source chosen by a direction's select input.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.data = d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.data;

    // R2 / R3: a strobe loads the bus value, no strobe holds the value
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cap |=> (q == $past(d)));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q));
    // R1: reset clears the register
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int   W             = 8,
    parameter logic OE_ACTIVE_LOW = 1'b0
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic         sel,
    input  logic         en,
    output logic [W-1:0] out,
    output logic [W-1:0] oe
);
    import xcvr_pkg::*;

    src_e src;
    logic act;

    assign src = src_e'(sel);

    for (genvar g = 0; g < W; g++) begin : g_chan
        assign out[g] = (src == SRC_STORED) ? stored[g] : live[g];
    end

    if (OE_ACTIVE_LOW) begin : g_low
        assign act = ~en;
    end else begin : g_high
        assign act = en;
    end

    assign oe = {W{act}};
endmodule

// File: rtl/xcvr_stagger_mon.sv
module xcvr_stagger_mon (
    input  logic clk,
    input  logic rst,
    input  logic cap_ab,
    input  logic cap_ba,
    input  logic sel_ab,
    input  logic sel_ba,
    output logic err
);
    typedef struct packed {
        logic err;
    } mon_t;

    mon_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (cap_ab && cap_ba && (sel_ab || sel_ba)) begin
            m_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign err = m_q.err;

    // R11: a violation sets the flag, and the flag never drops without reset
    p_set_r11: assert property (@(posedge clk) disable iff (rst)
        (cap_ab && cap_ba && (sel_ab || sel_ba)) |=> err);
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R1
    p_clear_r1: assert property (@(posedge clk)
        rst |=> !err);
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         en_ab,
    input  logic         en_ba_n,
    output logic         stagger_err
);
    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    // Storage registers, one per direction
    xcvr_store #(.W(W)) u_store_ab (
        .clk(clk), .rst(rst), .cap(cap_ab), .d(a_in), .q(ab_q)
    );
    xcvr_store #(.W(W)) u_store_ba (
        .clk(clk), .rst(rst), .cap(cap_ba), .d(b_in), .q(ba_q)
    );

    // Output paths: toward B (active-high enable), toward A (active-low enable)
    xcvr_drive #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_drive_b (
        .live(a_in), .stored(ab_q), .sel(sel_ab), .en(en_ab),
        .out(b_out), .oe(b_oe)
    );
    xcvr_drive #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_drive_a (
        .live(b_in), .stored(ba_q), .sel(sel_ba), .en(en_ba_n),
        .out(a_out), .oe(a_oe)
    );

    xcvr_stagger_mon u_mon (
        .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .err(stagger_err)
    );

    // R4: a value loaded from A reaches B one edge later through the stored path
    p_stored_ab_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_ab && sel_ab) |=> (!sel_ab || (b_out == $past(a_in))));
    // R5: same for the B-to-A direction
    p_stored_ba_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_ba && sel_ba) |=> (!sel_ba || (a_out == $past(b_in))));
    // R7: isolation drives neither bus
    p_isolate_r7: assert property (@(posedge clk) disable iff (rst)
        (!en_ab && en_ba_n) |-> ((a_oe == '0) && (b_oe == '0)));
    // R8: both enables active means both buses are driven
    p_dual_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (en_ab && !en_ba_n) |-> ((a_oe == '1) && (b_oe == '1)));
endmodule

// File: tb/tb_reg_bus_xcvr.sv
`timescale 1ns/100ps
module tb_reg_bus_xcvr;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, en_ab = 0, en_ba_n = 1;
    logic stagger_err;

    // outside drivers and keepers
    logic [W-1:0] ext_a = '0, ext_b = '0, keep_a = '0, keep_b = '0;
    logic ext_a_en = 0, ext_b_en = 0;

    // bench model
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_err = 0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    reg_bus_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .stagger_err(stagger_err)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // resolve both buses repeatedly so the loop through the block settles
    task automatic settle();
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] av, bv;
            av = ext_a_en ? ext_a : (a_oe[0] ? a_out : keep_a);
            bv = ext_b_en ? ext_b : (b_oe[0] ? b_out : keep_b);
            a_in = av; b_in = bv; keep_a = av; keep_b = bv;
            #0.1;
        end
    endtask

    // one clock edge; model follows the requirements; strobes last one cycle
    task automatic step();
        settle();
        if (rst) begin
            m_ab = '0; m_ba = '0; m_err = 0;
        end else begin
            if (cap_ab && cap_ba && (sel_ab || sel_ba)) m_err = 1;
            if (cap_ab) m_ab = a_in;
            if (cap_ba) m_ba = b_in;
        end
        @(posedge clk);
        #1;
        cap_ab = 0; cap_ba = 0;
        settle();
    endtask

    task automatic check_ports(input string tag);
        settle();
        chk({tag, " R4 b_out"}, b_out, sel_ab ? m_ab : a_in);
        chk({tag, " R5 a_out"}, a_out, sel_ba ? m_ba : b_in);
        chk({tag, " R6 b_oe"}, b_oe, {W{en_ab}});
        chk({tag, " R6 a_oe"}, a_oe, {W{~en_ba_n}});
        chk({tag, " R11 err"}, stagger_err, m_err);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset
        rst = 1; sel_ab = 1; sel_ba = 1;
        repeat (3) step();
        rst = 0;
        step();
        chk("R1 ab reg", b_out, 0);
        chk("R1 ba reg", a_out, 0);
        chk("R1 err", stagger_err, 0);

        // R2: load A while isolated and selecting live
        sel_ab = 0; sel_ba = 0; en_ab = 0; en_ba_n = 1;
        ext_a_en = 1; ext_a = 8'h6B; ext_b_en = 1; ext_b = 8'h94;
        cap_ab = 1; step();
        sel_ab = 1; settle();
        chk("R2 load while disabled", b_out, 8'h6B);
        ext_a = 8'h01; step(); step();
        chk("R2 hold without strobe", b_out, 8'h6B);

        // R3: load B
        cap_ba = 1; step();
        sel_ba = 1; settle();
        chk("R3 load", a_out, 8'h94);
        ext_b = 8'h77; step();
        chk("R3 hold without strobe", a_out, 8'h94);

        // R4/R5 live
        sel_ab = 0; sel_ba = 0; ext_a = 8'hC3; ext_b = 8'h3C; settle();
        chk("R4 live", b_out, 8'hC3);
        chk("R5 live", a_out, 8'h3C);

        // R7: isolation keeps undriven buses at keeper values
        ext_a_en = 0; ext_b_en = 0; settle();
        ext_a_en = 1; ext_a = 8'h5A; settle();
        chk("R7 b bus untouched", b_in, 8'h3C);
        chk("R7 a_oe", a_oe, 0);
        chk("R7 b_oe", b_oe, 0);

        // R8: dual stored transfer (registers hold 6B and 94)
        ext_a_en = 0; ext_b_en = 0;
        en_ab = 1; en_ba_n = 0; sel_ab = 1; sel_ba = 1; settle();
        chk("R8 B bus gets stored A", b_in, 8'h6B);
        chk("R8 A bus gets stored B", a_in, 8'h94);

        // R9: hold loop
        en_ab = 0; en_ba_n = 1; sel_ab = 0; sel_ba = 0; settle();
        ext_a_en = 1; ext_a = 8'hA5; en_ab = 1; en_ba_n = 0; settle();
        chk("R9 B follows A", b_in, 8'hA5);
        ext_a_en = 0; step(); step();
        chk("R9 A keeps value", a_in, 8'hA5);
        chk("R9 B keeps value", b_in, 8'hA5);

        // R10: load both registers from A through the live path
        en_ab = 1; en_ba_n = 1; ext_a_en = 1; ext_a = 8'h2E;
        cap_ab = 1; cap_ba = 1; step();
        sel_ab = 1; sel_ba = 1; ext_a = 8'h00; settle();
        chk("R10 A-to-B reg", b_out, 8'h2E);
        chk("R10 B-to-A reg", a_out, 8'h2E);
        chk("R10 no error", stagger_err, 0);

        // R11: simultaneous strobes with a stored select
        sel_ab = 1; sel_ba = 0; cap_ab = 1; cap_ba = 1; step();
        chk("R11 set", stagger_err, 1);
        step(); step();
        chk("R11 sticky", stagger_err, 1);
        rst = 1; step(); rst = 0; step();
        chk("R11 cleared by reset (R1)", stagger_err, 0);

        // random mix, outside drivers only where the block leaves a bus undriven
        for (int it = 0; it < 400; it++) begin
            en_ab = 1'($urandom); en_ba_n = 1'($urandom);
            sel_ab = 1'($urandom); sel_ba = 1'($urandom);
            cap_ab = ($urandom % 3) == 0; cap_ba = ($urandom % 3) == 0;
            ext_a = W'($urandom); ext_b = W'($urandom);
            ext_a_en = en_ba_n; ext_b_en = !en_ab;
            check_ports("rand pre");
            step();
            check_ports("rand post");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule